// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This block is an up-counting watchdog timer for a chip's supervision logic. A slow tick (nominally 32 kHz, given as a single-cycle enable) advances a counter through a programmable power-of-two prescaler. When the counter rolls over past its all-ones value, the block raises a one-cycle reset request for the system reset controller. Software keeps the system alive by writing the trigger register, which reloads the counter from the load register.

Arming and disarming are protected. Each requires an ordered pair of magic words written back to back to the run-control register. While the timer runs, the configuration registers are frozen, so a runaway program cannot lengthen the timeout or slow the prescaler. Every writable register has its own write-pending flag, which stays high for two clock cycles after the write.

Register map (word index on `wr_addr_i` / `rd_addr_i`): 0 control, 1 load, 2 counter (read only), 3 trigger, 4 run control, 5 write-pending status (read only).

Top module: `seq_wdt_top`

## Requirements
- R1: After synchronous reset, every register reads zero, the timer is stopped and `reset_req_o` is low.
- R2: Writing 0x0000BBBB to address 4, then 0x00004444 as the very next write, arms the timer. Bit 0 of a read from address 4 is 1 while armed.
- R3: Writing 0x0000AAAA to address 4, then 0x00005555 as the very next write, disarms the timer.
- R4: Any of the following leaves the run state unchanged and clears the partial sequence: a second word without its own first word, a first word followed by a different value, or a first word followed by a write to any other address. A new first word always restarts the sequence.
- R5: The counter (address 2, readable at any time) advances by one on each prescaled tick only while armed, and holds its value while stopped.
- R6: Control bit 5 enables the prescaler and bits 4:2 hold a ratio r. When enabled, the counter advances once per 2^r ticks. When disabled, it advances on every tick. A control write restarts the prescaler phase.
- R7: A write to address 3 whose data differs from the previous trigger data reloads the counter from the load register on the next clock. A write that repeats the previous data has no effect on the counter.
- R8: Writes to the control (0) and load (1) registers are ignored while the timer is armed.
- R9: When an armed counter at all-ones receives a prescaled tick, `reset_req_o` is high for exactly one cycle and the counter reloads from the load register.
- R10: Address 5 reports a pending write at bit 0 (control), bit 2 (load), bit 3 (trigger) and bit 4 (run control). Each bit reads 1 for the two clock cycles after a write to its register, ignored or not, and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow time-base tick, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data (combinational) |
| reset_req_o | output | 1 | One-cycle reset request on rollover |

## Verification
Several properties are checked on every cycle:
- The reset request is a single-cycle pulse that only appears while the timer is armed.
- The run state changes only right after a run-control write.
- Configuration stays frozen while armed.
- The counter stays frozen while stopped with no trigger.
- A control write raises its pending flag.

Other behaviours can only be shown by the bench scenarios:
- The exact ordering rules of the magic pairs.
- The prescaler ratio arithmetic over all eight ratios.
- The repeated-trigger rule.
- The rollover value and the reload.
- The two-cycle pending window.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_COUNT = 3'd2,
        A_TRIG  = 3'd3,
        A_RUN   = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    localparam logic [15:0] ARM_FIRST  = 16'hBBBB;
    localparam logic [15:0] ARM_SECOND = 16'h4444;
    localparam logic [15:0] DIS_FIRST  = 16'hAAAA;
    localparam logic [15:0] DIS_SECOND = 16'h5555;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARM_HALF,
        SQ_DIS_HALF
    } seq_state_e;

    localparam int RATIO_W = 3;

    typedef struct packed {
        logic               pre_en;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;

    localparam int CTRL_EN_BIT = 5;
    localparam int CTRL_RATIO_LSB = 2;

    localparam int NPEND = 4;
    localparam int PB_CTRL = 0;
    localparam int PB_LOAD = 2;
    localparam int PB_TRIG = 3;
    localparam int PB_RUN  = 4;

    function automatic logic match16(input logic [31:0] d, input logic [15:0] w);
        return d == {16'h0000, w};
    endfunction

endpackage

// File: rtl/seq_wdt_seqchk.sv
module seq_wdt_seqchk
    import seq_wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_run,
    input  logic        wr_other,
    input  logic [31:0] data,
    output logic        running
);
    seq_state_e st_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            run_q <= 1'b0;
        end else if (wr_run) begin
            if (st_q == SQ_ARM_HALF && match16(data, ARM_SECOND)) begin
                run_q <= 1'b1;
                st_q  <= SQ_IDLE;
            end else if (st_q == SQ_DIS_HALF && match16(data, DIS_SECOND)) begin
                run_q <= 1'b0;
                st_q  <= SQ_IDLE;
            end else if (match16(data, ARM_FIRST)) begin
                st_q <= SQ_ARM_HALF;
            end else if (match16(data, DIS_FIRST)) begin
                st_q <= SQ_DIS_HALF;
            end else begin
                st_q <= SQ_IDLE;
            end
        end else if (wr_other) begin
            st_q <= SQ_IDLE;
        end
    end

    assign running = run_q;
endmodule

// File: rtl/seq_wdt_prescale.sv
module seq_wdt_prescale
    import seq_wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               tick_in,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick_out
);
    localparam int PRE_W = 1 << RATIO_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;
    logic             wrap;

    always_comb begin
        one_sh = (PRE_W+1)'(1) << ratio;
        mask   = PRE_W'(one_sh - (PRE_W+1)'(1));
    end

    assign wrap     = (pre_q == mask);
    assign tick_out = tick_in && (!en || wrap);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (tick_in && en) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_wdt_pending.sv
module seq_wdt_pending
    import seq_wdt_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPEND-1:0] wr_vec,
    output logic [NPEND-1:0] pend
);
    localparam int HW = $clog2(HOLD + 1);

    for (genvar g = 0; g < NPEND; g++) begin : g_flag
        logic [HW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (wr_vec[g]) begin
                cnt_q <= HW'(HOLD);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
        assign pend[g] = (cnt_q != '0);
    end
endmodule

// File: rtl/seq_wdt_top.sv
module seq_wdt_top
    import seq_wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [2:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        reset_req_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      trig_q;
    logic             req_q;
    logic             running;
    logic             ctick;
    logic [NPEND-1:0] pend;

    logic wr_ctrl, wr_load, wr_trig, wr_run, trig_hit, cfg_ok;

    assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_load  = wr_en_i && (wr_addr_i == A_LOAD);
    assign wr_trig  = wr_en_i && (wr_addr_i == A_TRIG);
    assign wr_run   = wr_en_i && (wr_addr_i == A_RUN);
    assign trig_hit = wr_trig && (wr_data_i != trig_q);
    assign cfg_ok   = !running;

    seq_wdt_seqchk u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_run   (wr_run),
        .wr_other (wr_en_i && !wr_run),
        .data     (wr_data_i),
        .running  (running)
    );

    seq_wdt_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (wr_ctrl && cfg_ok),
        .tick_in  (tick_i && running),
        .en       (ctrl_q.pre_en),
        .ratio    (ctrl_q.ratio),
        .tick_out (ctick)
    );

    seq_wdt_pending #(.HOLD(2)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .wr_vec ({wr_run, wr_trig, wr_load, wr_ctrl}),
        .pend   (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (wr_ctrl && cfg_ok) begin
                ctrl_q.pre_en <= wr_data_i[CTRL_EN_BIT];
                ctrl_q.ratio  <= wr_data_i[CTRL_RATIO_LSB +: RATIO_W];
            end
            if (wr_load && cfg_ok) load_q <= wr_data_i[CNT_W-1:0];
            if (wr_trig) trig_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (trig_hit) begin
                cnt_q <= load_q;
            end else if (running && ctick) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= load_q;
                    req_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL: begin
                rd_data_o[CTRL_EN_BIT] = ctrl_q.pre_en;
                rd_data_o[CTRL_RATIO_LSB +: RATIO_W] = ctrl_q.ratio;
            end
            A_LOAD:  rd_data_o[CNT_W-1:0] = load_q;
            A_COUNT: rd_data_o[CNT_W-1:0] = cnt_q;
            A_TRIG:  rd_data_o = trig_q;
            A_RUN:   rd_data_o[0] = running;
            A_STAT: begin
                rd_data_o[PB_CTRL] = pend[0];
                rd_data_o[PB_LOAD] = pend[1];
                rd_data_o[PB_TRIG] = pend[2];
                rd_data_o[PB_RUN]  = pend[3];
            end
            default: rd_data_o = '0;
        endcase
    end

    assign reset_req_o = req_q;
endmodule

// File: rtl/seq_wdt_chk.sv
module seq_wdt_chk
    import seq_wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic             running,
    input logic [3:0]       ctrl_bits,
    input logic [CNT_W-1:0] load,
    input logic [CNT_W-1:0] cnt,
    input logic [31:0]      trig_last,
    input logic [NPEND-1:0] pend,
    input logic             req
);
    logic run_wr, trig_new;
    assign run_wr   = wr_en && (wr_addr == A_RUN);
    assign trig_new = wr_en && (wr_addr == A_TRIG) && (wr_data != trig_last);

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R9
    req_armed_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(running));

    // R2 R3 R4
    run_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(running) |-> $past(run_wr));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(running) |-> ($stable(ctrl_bits) && $stable(load)));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!running && !trig_new) |-> $stable(cnt));

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CTRL) |=> pend[0]);
endmodule

bind seq_wdt_top seq_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .running   (running),
    .ctrl_bits (ctrl_q),
    .load      (load_q),
    .cnt       (cnt_q),
    .trig_last (trig_q),
    .pend      (pend),
    .req       (req_q)
);

// File: tb/sim_seq_wdt_top.sv
module sim_seq_wdt_top;
    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = 3'd0;
    logic [31:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = 3'd0;
    logic [31:0] rd_data_o;
    logic        reset_req_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [31:0] tv = 32'h100;

    always #5 clk = ~clk;

    seq_wdt_top #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .reset_req_o(reset_req_o)
    );

    always @(negedge clk) if (!rst && reset_req_o) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic new_trig;
        tv = tv + 1;
        wr(3'd3, tv);
    endtask

    task automatic arm;    wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444); endtask
    task automatic disarm; wr(3'd4, 32'hAAAA); wr(3'd4, 32'h5555); endtask

    initial begin : watchdog
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] snap;
        int          pb [4];
        logic [2:0]  pa [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1", d, 32'h0);
        end
        check("R1 reset_req", {31'b0, reset_req_o}, 32'h0);

        // R4 broken sequences, R2 arm, R3 disarm
        wr(3'd4, 32'h4444); rd(3'd4, d); check("R4 lone second word", d, 0);
        wr(3'd4, 32'hBBBB); wr(3'd1, 32'h5); wr(3'd4, 32'h4444);
        rd(3'd4, d); check("R4 interleaved write", d, 0);
        wr(3'd4, 32'hBBBB); wr(3'd4, 32'h1234); wr(3'd4, 32'h4444);
        rd(3'd4, d); check("R4 wrong value", d, 0);
        wr(3'd4, 32'hBBBB); wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444);
        rd(3'd4, d); check("R2 restarted first word", d, 1);
        wr(3'd4, 32'hAAAA); wr(3'd4, 32'h4444);
        rd(3'd4, d); check("R4 mixed pair", d, 1);
        wr(3'd4, 32'h5555); rd(3'd4, d); check("R4 lone disarm word", d, 1);
        wr(3'd4, 32'hAAAA); wr(3'd3, 32'h7); wr(3'd4, 32'h5555);
        rd(3'd4, d); check("R4 interleaved disarm", d, 1);
        disarm; rd(3'd4, d); check("R3 disarm", d, 0);

        // R6 prescaler sweep with R5 counting
        for (int r = 0; r < 8; r++) begin
            wr(3'd0, 32'h20 | (r << 2));
            wr(3'd1, 32'h0);
            new_trig;
            arm;
            ticks(3 << r);
            rd(3'd2, d); check($sformatf("R6 ratio %0d", r), d, 3);
            if (r > 0) begin
                ticks((1 << r) - 1);
                rd(3'd2, d); check($sformatf("R6 ratio %0d partial", r), d, 3);
            end
            disarm;
        end
        wr(3'd0, 32'h14);
        new_trig;
        arm;
        ticks(5);
        rd(3'd2, d); check("R6 prescaler off", d, 5);
        disarm;
        ticks(4);
        rd(3'd2, d); check("R5 hold when stopped", d, 5);

        // R8 config ignored while running, R7 trigger
        wr(3'd0, 32'h0); wr(3'd1, 32'h10); new_trig; arm;
        wr(3'd0, 32'h3C); wr(3'd1, 32'h77);
        rd(3'd0, d); check("R8 control frozen", d, 0);
        rd(3'd1, d); check("R8 load frozen", d, 32'h10);
        new_trig; rd(3'd2, d); check("R7 reload", d, 32'h10);
        ticks(2); rd(3'd2, d); check("R5 count running", d, 32'h12);
        wr(3'd3, tv); rd(3'd2, d); check("R7 repeated value", d, 32'h12);
        new_trig; rd(3'd2, d); check("R7 new value", d, 32'h10);

        // R9 rollover
        disarm;
        wr(3'd1, 32'hF0); new_trig; arm;
        ticks(15);
        rd(3'd2, d); check("R9 at max", d, 32'hFF);
        check("R9 no early pulse", pulses, 0);
        ticks(1);
        check("R9 pulse", {31'b0, reset_req_o}, 1);
        rd(3'd2, d); check("R9 reload", d, 32'hF0);
        @(negedge clk);
        check("R9 single cycle", {31'b0, reset_req_o}, 0);
        check("R9 pulse count", pulses, 1);
        disarm;

        // R10 pending flags
        pb = '{0, 2, 3, 4};
        pa = '{3'd0, 3'd1, 3'd3, 3'd4};
        for (int k = 0; k < 4; k++) begin
            repeat (3) @(negedge clk);
            wr(pa[k], 32'h0);
            rd(3'd5, d); check($sformatf("R10 bit %0d first", pb[k]), d, 32'(1) << pb[k]);
            @(negedge clk);
            rd(3'd5, d); check($sformatf("R10 bit %0d second", pb[k]), d, 32'(1) << pb[k]);
            @(negedge clk);
            rd(3'd5, d); check($sformatf("R10 bit %0d clear", pb[k]), d, 0);
        end

        // R5 counter readable while stopped, unaffected by reads
        rd(3'd2, snap); rd(3'd2, d);
        check("R5 stable readback", d, snap);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule